// File: doc/BRIEF.md
# Two-Key Write Guard for a Register Bank

This block sits on the write path between a bus master and a bank of peripheral registers. Some of those registers hold timekeeping, alarm, interrupt-enable, status-clear, control and oscillator settings. Stray writes to them are harmful, so the block forwards a write to any of them only while the bank is open. The bank opens after two 32-bit keys are written in order to two dedicated key words. While the bank is closed, writes to protected words are dropped without any response. Words outside the protected set are never gated. Reads do not pass through the block and are never affected by it.

Writing any value other than its key to either key word closes the bank again. The usual way to close it is to write zero to both key words. A wrong value also discards a half-finished unlock. The key words belong to the guard itself and are never passed on to the bank. A single `locked` output shows whether the bank is currently closed. The key values, the key word offsets and the map of protected words are parameters. Their defaults place the keys at byte offsets 0x6C and 0x70.

Top module: `wpk_guard`

## Requirements
- R1: After reset `locked` is 1 and no write reaches the bank until both keys have been accepted.
- R2: While `locked` is 1, a write to a protected word (default map: word indices 0 to 6, 8 to 13 and 16 to 21, where word index = byte address bits [7:2]) does not raise `bank_we`. The bank contents read afterwards are unchanged.
- R3: Writing 0x83E70B13 to the first key word (byte offset 0x6C) and then 0x95A4F1E0 to the second key word (byte offset 0x70) opens the bank. After the first key alone, `locked` stays 1. `locked` reads 0 from the clock edge that accepts the second key.
- R4: The second key written while no first key is held leaves the bank closed. A first key written afterwards does not open the bank by itself. A further second key then opens it.
- R5: After the first key has been accepted, a wrong value written to either key word discards that progress. A following second key then leaves `locked` at 1.
- R6: While `locked` is 0, a write to a protected word raises `bank_we` in the same cycle.
- R7: While the bank is open, writing zero, or any value other than its key, to either key word sets `locked` to 1 from the next clock edge.
- R8: A write to a word that is neither protected nor a key word raises `bank_we` in the same cycle, whatever the lock state.
- R9: A write to either key word never raises `bank_we`.
- R10: While the bank is open, writing the correct first key or the correct second key again keeps it open.
- R11: Address bits [1:0] are ignored when the word is decoded, for key words and for protected words.
- R12: `bank_addr` and `bank_wdata` carry `wr_addr` and `wr_data` in the same cycle, so a forwarded write has the address and data that were presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request from the bus side |
| wr_addr | input | ADDR_W (8) | Byte address of the write |
| wr_data | input | DATA_W (32) | Write data |
| bank_we | output | 1 | Write strobe to the register bank, after gating |
| bank_addr | output | ADDR_W (8) | Address presented to the bank |
| bank_wdata | output | DATA_W (32) | Data presented to the bank |
| locked | output | 1 | 1 while protected writes are being dropped |

## Verification
The hardest condition to reach is the half-open state after the first key has been accepted. It cannot be seen on `locked`, so it is only visible through what the next key-word write does. The stimulus reaches it by writing the first key and then following with a wrong first key, a wrong second key, or the second key before the first, each time finishing with a correct second key. Whether the bank opens then reveals whether the hidden progress was kept or cleared. Around these sequences, every word of the address space is written once with the bank closed and once with it open, using varying low address bits. The resulting bank image is compared with the one the bench predicts.

// File: rtl/wpk_pkg.sv
package wpk_pkg;

   // decoded class of one write access
   typedef enum logic [1:0] {
      AC_OPEN   = 2'd0,
      AC_PROT   = 2'd1,
      AC_KICK_A = 2'd2,
      AC_KICK_B = 2'd3
   } acc_cls_e;

   // progress of the two-key unlock
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } kick_st_e;

endpackage

// File: rtl/wpk_addr_map.sv
module wpk_addr_map #(
   parameter int                       WORD_W      = 6,
   parameter logic [(1<<WORD_W)-1:0]   PROT_MASK   = '0,
   parameter logic [WORD_W-1:0]        KICK_A_WORD = '0,
   parameter logic [WORD_W-1:0]        KICK_B_WORD = '1
) (
   input  logic [WORD_W-1:0]  word,
   output wpk_pkg::acc_cls_e  cls
);
   import wpk_pkg::*;

   localparam int NWORDS = 1 << WORD_W;

   logic [NWORDS-1:0] prot_hit;

   // one comparator per word that the mask marks as protected
   for (genvar gw = 0; gw < NWORDS; gw++) begin : g_word
      if (PROT_MASK[gw]) begin : g_on
         assign prot_hit[gw] = (word == WORD_W'(gw));
      end else begin : g_off
         assign prot_hit[gw] = 1'b0;
      end
   end

   always_comb begin
      if (word == KICK_A_WORD)      cls = AC_KICK_A;
      else if (word == KICK_B_WORD) cls = AC_KICK_B;
      else if (|prot_hit)           cls = AC_PROT;
      else                          cls = AC_OPEN;
   end

endmodule

// File: rtl/wpk_kick_seq.sv
module wpk_kick_seq #(
   parameter int                DATA_W = 32,
   parameter logic [DATA_W-1:0] KEY_A  = '1,
   parameter logic [DATA_W-1:0] KEY_B  = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  wpk_pkg::acc_cls_e  cls,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               locked
);
   import wpk_pkg::*;

   kick_st_e st_q, st_d;
   logic     key_a_ok, key_b_ok;

   assign key_a_ok = (wr_data == KEY_A);
   assign key_b_ok = (wr_data == KEY_B);

   always_comb begin
      st_d = st_q;
      if (wr_en) begin
         case (cls)
            AC_KICK_A: begin
               if (!key_a_ok)             st_d = KS_LOCKED;
               else if (st_q != KS_OPEN)  st_d = KS_HALF;
            end
            AC_KICK_B: begin
               if (key_b_ok && (st_q != KS_LOCKED)) st_d = KS_OPEN;
               else                                 st_d = KS_LOCKED;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_LOCKED;
      else        st_q <= st_d;
   end

   assign locked = (st_q != KS_OPEN);

endmodule

// File: rtl/wpk_strobe_gate.sv
module wpk_strobe_gate (
   input  logic              wr_en,
   input  wpk_pkg::acc_cls_e cls,
   input  logic              locked,
   output logic              bank_we
);
   import wpk_pkg::*;

   always_comb begin
      case (cls)
         AC_OPEN: bank_we = wr_en;
         AC_PROT: bank_we = wr_en & ~locked;
         default: bank_we = 1'b0;
      endcase
   end

endmodule

// File: rtl/wpk_guard.sv
module wpk_guard #(
   parameter int                             ADDR_W     = 8,
   parameter int                             DATA_W     = 32,
   parameter logic [ADDR_W-1:0]              KICK_A_OFS = 'h6C,
   parameter logic [ADDR_W-1:0]              KICK_B_OFS = 'h70,
   parameter logic [DATA_W-1:0]              KEY_A      = 'h83E70B13,
   parameter logic [DATA_W-1:0]              KEY_B      = 'h95A4F1E0,
   parameter logic [(1<<(ADDR_W-2))-1:0]     PROT_MASK  = 'h003F3F7F
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic               bank_we,
   output logic [ADDR_W-1:0]  bank_addr,
   output logic [DATA_W-1:0]  bank_wdata,
   output logic               locked
);
   import wpk_pkg::*;

   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] KA_WORD = KICK_A_OFS[ADDR_W-1:2];
   localparam logic [WORD_W-1:0] KB_WORD = KICK_B_OFS[ADDR_W-1:2];

   // elaboration-time parameter checks
   if (ADDR_W < 3 || ADDR_W > 12) begin : g_bad_aw
      $error("wpk_guard: ADDR_W must lie in 3..12");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("wpk_guard: DATA_W must be positive");
   end
   if (KICK_A_OFS[1:0] != 2'b00 || KICK_B_OFS[1:0] != 2'b00) begin : g_bad_align
      $error("wpk_guard: key offsets must be word aligned");
   end
   if (KA_WORD == KB_WORD) begin : g_bad_same
      $error("wpk_guard: key words must differ");
   end
   if (PROT_MASK[KA_WORD] || PROT_MASK[KB_WORD]) begin : g_bad_overlap
      $error("wpk_guard: key words may not be in the protected map");
   end
   if (KEY_A == '0 || KEY_B == '0) begin : g_bad_key
      $error("wpk_guard: zero is the relock value and cannot be a key");
   end

   acc_cls_e cls;
   logic     lock_q;

   wpk_addr_map #(
      .WORD_W      (WORD_W),
      .PROT_MASK   (PROT_MASK),
      .KICK_A_WORD (KA_WORD),
      .KICK_B_WORD (KB_WORD)
   ) u_map (
      .word (wr_addr[ADDR_W-1:2]),
      .cls  (cls)
   );

   wpk_kick_seq #(
      .DATA_W (DATA_W),
      .KEY_A  (KEY_A),
      .KEY_B  (KEY_B)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .cls     (cls),
      .wr_data (wr_data),
      .locked  (lock_q)
   );

   wpk_strobe_gate u_gate (
      .wr_en   (wr_en),
      .cls     (cls),
      .locked  (lock_q),
      .bank_we (bank_we)
   );

   assign bank_addr  = wr_addr;
   assign bank_wdata = wr_data;
   assign locked     = lock_q;

endmodule

// File: rtl/wpk_guard_chk.sv
module wpk_guard_chk #(
   parameter int                             ADDR_W     = 8,
   parameter int                             DATA_W     = 32,
   parameter logic [ADDR_W-1:0]              KICK_A_OFS = 'h6C,
   parameter logic [ADDR_W-1:0]              KICK_B_OFS = 'h70,
   parameter logic [DATA_W-1:0]              KEY_A      = 'h83E70B13,
   parameter logic [DATA_W-1:0]              KEY_B      = 'h95A4F1E0,
   parameter logic [(1<<(ADDR_W-2))-1:0]     PROT_MASK  = 'h003F3F7F
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-3:0]  wr_word,
   input logic [DATA_W-1:0]  wr_data,
   input logic               bank_we,
   input logic               locked
);
   localparam logic [ADDR_W-3:0] KA_W = KICK_A_OFS[ADDR_W-1:2];
   localparam logic [ADDR_W-3:0] KB_W = KICK_B_OFS[ADDR_W-1:2];

   logic is_ka, is_kb, is_prot;
   assign is_ka   = (wr_word == KA_W);
   assign is_kb   = (wr_word == KB_W);
   assign is_prot = PROT_MASK[wr_word];

   AST_RESET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> locked);                                              // R1

   AST_NO_WE_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && locked && is_prot) |-> !bank_we);                            // R2

   AST_OPEN_ONLY_BY_KEY_B: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(wr_en && is_kb && (wr_data == KEY_B)));        // R3

   AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !locked && is_prot) |-> bank_we);                            // R6

   AST_WRONG_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ((is_ka && wr_data != KEY_A) || (is_kb && wr_data != KEY_B)))
      |=> locked);                                                           // R7

   AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_prot && !is_ka && !is_kb) |-> bank_we);                  // R8

   AST_KICK_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (is_ka || is_kb)) |-> !bank_we);                             // R9

endmodule

bind wpk_guard wpk_guard_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .KICK_A_OFS (KICK_A_OFS),
   .KICK_B_OFS (KICK_B_OFS),
   .KEY_A      (KEY_A),
   .KEY_B      (KEY_B),
   .PROT_MASK  (PROT_MASK)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_word (wr_addr[ADDR_W-1:2]),
   .wr_data (wr_data),
   .bank_we (bank_we),
   .locked  (locked)
);

// File: tb/wpk_guard_tb.sv
module wpk_guard_tb;

   localparam logic [31:0] KA = 32'h83E70B13;
   localparam logic [31:0] KB = 32'h95A4F1E0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        bank_we;
   logic [7:0]  bank_addr;
   logic [31:0] bank_wdata;
   logic        locked;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   int exp_st = 0;              // 0 closed, 1 first key held, 2 open
   logic [31:0] exp_mem [64];
   logic [31:0] mem [64];

   always #10 clk = ~clk;       // 50 MHz

   wpk_guard u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .bank_we    (bank_we),
      .bank_addr  (bank_addr),
      .bank_wdata (bank_wdata),
      .locked     (locked)
   );

   // stand-in register bank behind the guard
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) mem[i] <= '0;
      end else if (bank_we) begin
         mem[bank_addr[7:2]] <= bank_wdata;
      end
   end

   function automatic bit is_prot(int w);
      return (w <= 6) || (w >= 8 && w <= 13) || (w >= 16 && w <= 21);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
      int  w;
      bit  kick, exp_we;
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #2;
      w      = int'(a[7:2]);
      kick   = (w == 27) || (w == 28);
      exp_we = !kick && (!is_prot(w) || exp_st == 2);
      chk({tag, " bank_we"}, 32'(bank_we), 32'(exp_we));
      if (exp_we) begin
         chk("R12 bank_addr", 32'(bank_addr), 32'(a));
         chk("R12 bank_wdata", bank_wdata, d);
         exp_mem[w] = d;
      end
      if (w == 27) exp_st = (d == KA) ? ((exp_st == 2) ? 2 : 1) : 0;
      if (w == 28) exp_st = (d == KB && exp_st >= 1) ? 2 : 0;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic chk_lock(string tag);
      @(negedge clk);
      chk({tag, " locked"}, 32'(locked), 32'(exp_st != 2));
   endtask

   task automatic open_bank();
      wr(8'h6C, KA, "R9");
      wr(8'h70, KB, "R9");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) exp_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset locked", 32'(locked), 32'd1);
      rst_n = 1'b1;
      chk_lock("R1 after release");

      // closed: sweep every word with varying low address bits
      for (int w = 0; w < 64; w++) begin
         if (w == 27 || w == 28) continue;
         wr({6'(w), 2'(w)}, 32'hC0DE0000 | 32'(w), is_prot(w) ? "R2 R11" : "R8 R11");
      end
      chk_lock("R1 still closed");
      wr(8'h6C, 32'h00001234, "R9");
      chk_lock("R7 wrong key closed");

      // unlock in two steps
      wr(8'h6C, KA, "R9");
      chk_lock("R3 first key only");
      wr(8'h70, KB, "R9");
      chk_lock("R3 opened");

      // open: sweep every word
      for (int w = 0; w < 64; w++) begin
         if (w == 27 || w == 28) continue;
         wr({6'(w), 2'(3 - (w % 4))}, 32'h5A5A0000 ^ (32'(w) << 8), is_prot(w) ? "R6" : "R8");
      end
      chk_lock("R6 still open");

      wr(8'h6C, KA, "R10");
      chk_lock("R10 key A again");
      wr(8'h70, KB, "R10");
      chk_lock("R10 key B again");

      // relock by zero on the second key word
      wr(8'h70, 32'h0, "R7");
      chk_lock("R7 zero on B");
      wr(8'h04, 32'hDEADBEEF, "R2");
      // relock by zero on the first key word
      open_bank();
      chk_lock("R3 reopen");
      wr(8'h6C, 32'h0, "R7");
      chk_lock("R7 zero on A");
      wr(8'h20, 32'hFEEDF00D, "R2");
      // relock by a near-miss value
      open_bank();
      wr(8'h70, KB ^ 32'h1, "R7");
      chk_lock("R7 near-miss B");

      // order: second key before first
      wr(8'h70, KB, "R4");
      chk_lock("R4 B alone");
      wr(8'h6C, KA, "R4");
      chk_lock("R4 A after B");
      wr(8'h70, KB, "R4");
      chk_lock("R4 B after A");
      wr(8'h70, 32'h0, "R7");

      // lost progress
      wr(8'h6C, KA, "R5");
      wr(8'h6C, KA ^ 32'h80000000, "R5");
      wr(8'h70, KB, "R5");
      chk_lock("R5 wrong A clears");
      wr(8'h6C, KA, "R5");
      wr(8'h70, 32'h95A4F1E1, "R5");
      wr(8'h70, KB, "R5");
      chk_lock("R5 wrong B clears");
      wr(8'h54, 32'h13572468, "R2");

      // key words reached through unaligned addresses
      wr(8'h6F, KA, "R11");
      wr(8'h71, KB, "R11");
      chk_lock("R11 unaligned keys");
      wr(8'h72, 32'h0, "R11");
      chk_lock("R11 unaligned relock");

      // read back the bank image
      @(negedge clk);
      for (int w = 0; w < 64; w++) chk("R2 readback", mem[w], exp_mem[w]);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule